// File: doc/BRIEF.md
# User-Enable Control Register Access Router

This block sits beside the system-register file of a processor core. It recognises read and write requests addressed to the 4-bit user-enable control register through that register's five-field system encoding. For each access it picks one outcome from the current privilege level (0 to 3) and a set of trap-control flags: return the register value, commit a write, raise a trap toward level 2 or level 3, or report the access as undefined. It also holds the 4-bit register itself and drives its value out to the rest of the core. Taking the exception is left to the core.

The response path is registered. A request strobe in one cycle produces a response in the next cycle. That response carries the outcome, the target level, the syndrome class and the read data. A small state machine has two states. `ST_IDLE` means no response is pending. `ST_RESP` means a response is being presented. The transition `IDLE->RESP` fires on a request. `RESP->RESP` fires on a back-to-back request. `RESP->IDLE` fires when no new request arrives. Requests whose encoding does not match pass through with a no-match flag and cause no side effect.

Top module: `ugate_router`

## Requirements
- R1: The register is selected only when op0=2'b11, op1=3'b011, CRn=4'b1001, CRm=4'b1110 and op2=3'b000. Any other encoding gives a response with `rsp_nomatch`=1, outcome 0 (pass), target 0 and syndrome 0, and leaves `ctl_bits` unchanged.
- R2: `rsp_valid` is 1 exactly in the cycle after each cycle with `req_valid`=1. The outcome codes are 0 pass, 1 read, 2 write, 3 trap and 4 undefined.
- R3: A level-0 read is checked in a fixed order. First comes the fine-grained read trap to level 2. It applies when level 2 is enabled, level 1 is 64-bit, and level 3 is absent or its fine-grained enable is set. Next comes the level-2 monitor trap to level 2, which needs level 2 enabled and 64-bit. Last comes the level-3 monitor trap to level 3, which needs level 3 present and 64-bit. If none applies, the access is a read.
- R4: At level 0 the fine-grained read trap is suppressed only when the host-mode and route-to-hypervisor flags are both 1.
- R5: A level-1 read follows the R3 order, with two differences. Its fine-grained condition needs level 2 to be 64-bit rather than level 1. It has no host/route exemption.
- R6: A level-1 write follows the R5 order but uses the fine-grained write trap bit in place of the read bit. A trapped write leaves `ctl_bits` unchanged.
- R7: At level 2, reads and writes check only the level-3 monitor trap, which needs level 3 present and 64-bit.
- R8: At level 3, every read and every write succeeds, whatever the flags.
- R9: Every level-0 write is reported undefined (outcome 4, target 0) and leaves `ctl_bits` unchanged.
- R10: A trap reports syndrome 6'h18 with target 2 or 3. Every other outcome reports syndrome 0 and target 0.
- R11: Reset clears `ctl_bits` to 0. A successful write stores bits [3:0] of the write data. A read returns the stored bits zero-extended to 64 bits. Read data is 0 for any non-read outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current privilege level |
| l2_enabled | input | 1 | Level 2 enabled for the current state |
| l3_present | input | 1 | Level 3 implemented |
| l1_is64 | input | 1 | Level 1 runs 64-bit |
| l2_is64 | input | 1 | Level 2 runs 64-bit |
| l3_is64 | input | 1 | Level 3 runs 64-bit |
| fg_rd_trap | input | 1 | Fine-grained read trap bit |
| fg_wr_trap | input | 1 | Fine-grained write trap bit |
| l2_mon_trap | input | 1 | Level-2 monitor trap bit |
| l3_mon_trap | input | 1 | Level-3 monitor trap bit |
| l3_fg_enable | input | 1 | Level-3 enable for fine-grained traps |
| host_mode | input | 1 | Hypervisor host-mode flag |
| route_to_hyp | input | 1 | Hypervisor route-general flag |
| rsp_valid | output | 1 | Response valid |
| rsp_outcome | output | 3 | Outcome code (R2) |
| rsp_target | output | 2 | Trap target level |
| rsp_syndrome | output | 6 | Syndrome class |
| rsp_rdata | output | 64 | Read data |
| rsp_nomatch | output | 1 | Encoding did not match |
| ctl_bits | output | 4 | Stored register value |

## Verification
One edge can commit a write to the register and also register a response. The request sampled at the following edge can be a read of that same register. The bench provokes this by issuing a level-3 write and then, in the very next cycle, a read. It judges the pair by requiring that the read returns the freshly written low four bits. The high write-data bits must not appear. The write's own response must show outcome 2 with zero read data.

// File: rtl/ugate_pkg.sv
package ugate_pkg;

    typedef enum logic [2:0] {
        OC_PASS  = 3'd0,
        OC_READ  = 3'd1,
        OC_WRITE = 3'd2,
        OC_TRAP  = 3'd3,
        OC_UNDEF = 3'd4
    } outcome_e;

    typedef struct packed {
        logic l2_en;
        logic l3_pres;
        logic l1_64;
        logic l2_64;
        logic l3_64;
        logic fg_rd;
        logic fg_wr;
        logic l2_mon;
        logic l3_mon;
        logic l3_fge;
        logic host;
        logic route;
    } trap_ctl_t;

    localparam logic [1:0] ENC_OP0 = 2'b11;
    localparam logic [2:0] ENC_OP1 = 3'b011;
    localparam logic [3:0] ENC_CRN = 4'b1001;
    localparam logic [3:0] ENC_CRM = 4'b1110;
    localparam logic [2:0] ENC_OP2 = 3'b000;

endpackage

// File: rtl/ugate_decode.sv
module ugate_decode #(
    parameter logic [1:0] OP0 = 2'b11,
    parameter logic [2:0] OP1 = 3'b011,
    parameter logic [3:0] CRN = 4'b1001,
    parameter logic [3:0] CRM = 4'b1110,
    parameter logic [2:0] OP2 = 3'b000
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);
    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] KEY = {OP0, OP1, CRN, CRM, OP2};

    logic [KEY_W-1:0] req_key;

    always_comb begin
        req_key = {op0, op1, crn, crm, op2};
        hit     = (req_key == KEY);
    end
endmodule

// File: rtl/ugate_prio.sv
module ugate_prio
    import ugate_pkg::*;
(
    input  logic [1:0] el,
    input  logic       write,
    input  trap_ctl_t  tc,
    output outcome_e   outcome,
    output logic [1:0] target
);
    logic fgt_gate;
    logic fg0_hit;
    logic fg1_hit;
    logic mon2_hit;
    logic mon3_hit;
    outcome_e ok_code;

    always_comb begin
        fgt_gate = !tc.l3_pres || tc.l3_fge;
        fg0_hit  = tc.l2_en && tc.l1_64 && !(tc.host && tc.route) && fgt_gate && tc.fg_rd;
        fg1_hit  = tc.l2_en && tc.l2_64 && fgt_gate && (write ? tc.fg_wr : tc.fg_rd);
        mon2_hit = tc.l2_en && tc.l2_64 && tc.l2_mon;
        mon3_hit = tc.l3_pres && tc.l3_64 && tc.l3_mon;
        ok_code  = write ? OC_WRITE : OC_READ;
    end

    always_comb begin
        outcome = ok_code;
        target  = 2'd0;
        unique case (el)
            2'd0: begin
                if (write) begin
                    outcome = OC_UNDEF;
                end else if (fg0_hit || mon2_hit) begin
                    outcome = OC_TRAP;
                    target  = 2'd2;
                end else if (mon3_hit) begin
                    outcome = OC_TRAP;
                    target  = 2'd3;
                end
            end
            2'd1: begin
                if (fg1_hit || mon2_hit) begin
                    outcome = OC_TRAP;
                    target  = 2'd2;
                end else if (mon3_hit) begin
                    outcome = OC_TRAP;
                    target  = 2'd3;
                end
            end
            2'd2: begin
                if (mon3_hit) begin
                    outcome = OC_TRAP;
                    target  = 2'd3;
                end
            end
            default: begin
                outcome = ok_code;
            end
        endcase
    end
endmodule

// File: rtl/ugate_store.sv
module ugate_store #(
    parameter int DATA_W = 64,
    parameter int CTL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTL_W-1:0]  ctl_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (we) begin
            ctl_q <= wdata[CTL_W-1:0];
        end
    end
endmodule

// File: rtl/ugate_router.sv
module ugate_router
    import ugate_pkg::*;
#(
    parameter int          DATA_W   = 64,
    parameter int          CTL_W    = 4,
    parameter int          SYN_W    = 6,
    parameter logic [5:0]  SYN_CODE = 6'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        cur_el,
    input  logic              l2_enabled,
    input  logic              l3_present,
    input  logic              l1_is64,
    input  logic              l2_is64,
    input  logic              l3_is64,
    input  logic              fg_rd_trap,
    input  logic              fg_wr_trap,
    input  logic              l2_mon_trap,
    input  logic              l3_mon_trap,
    input  logic              l3_fg_enable,
    input  logic              host_mode,
    input  logic              route_to_hyp,
    output logic              rsp_valid,
    output logic [2:0]        rsp_outcome,
    output logic [1:0]        rsp_target,
    output logic [SYN_W-1:0]  rsp_syndrome,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_nomatch,
    output logic [CTL_W-1:0]  ctl_bits
);
    localparam int PAD_W = DATA_W - CTL_W;

    typedef enum logic {ST_IDLE, ST_RESP} state_e;

    state_e    state_q, state_d;
    trap_ctl_t tc;
    logic      hit;
    outcome_e  prio_oc;
    logic [1:0] prio_tgt;
    outcome_e  oc_d, oc_q;
    logic [1:0] tgt_d, tgt_q;
    logic [SYN_W-1:0] syn_d, syn_q;
    logic [DATA_W-1:0] rdata_d, rdata_q;
    logic      nomatch_d, nomatch_q;
    logic      store_we;
    logic [CTL_W-1:0] ctl_q;

    always_comb begin
        tc = '{l2_en: l2_enabled, l3_pres: l3_present, l1_64: l1_is64,
               l2_64: l2_is64, l3_64: l3_is64, fg_rd: fg_rd_trap,
               fg_wr: fg_wr_trap, l2_mon: l2_mon_trap, l3_mon: l3_mon_trap,
               l3_fge: l3_fg_enable, host: host_mode, route: route_to_hyp};
    end

    ugate_decode #(
        .OP0(ENC_OP0), .OP1(ENC_OP1), .CRN(ENC_CRN), .CRM(ENC_CRM), .OP2(ENC_OP2)
    ) u_decode (
        .op0(req_op0), .op1(req_op1), .crn(req_crn), .crm(req_crm), .op2(req_op2),
        .hit(hit)
    );

    ugate_prio u_prio (
        .el(cur_el), .write(req_write), .tc(tc),
        .outcome(prio_oc), .target(prio_tgt)
    );

    ugate_store #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(store_we), .wdata(req_wdata), .ctl_q(ctl_q)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;
            ST_RESP: if (!req_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Response contents for the request being sampled
    always_comb begin
        oc_d      = hit ? prio_oc : OC_PASS;
        tgt_d     = hit ? prio_tgt : 2'd0;
        nomatch_d = !hit;
        syn_d     = (oc_d == OC_TRAP) ? SYN_CODE[SYN_W-1:0] : '0;
        rdata_d   = (oc_d == OC_READ) ? {{PAD_W{1'b0}}, ctl_q} : '0;
        store_we  = req_valid && (oc_d == OC_WRITE);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oc_q      <= OC_PASS;
            tgt_q     <= 2'd0;
            syn_q     <= '0;
            rdata_q   <= '0;
            nomatch_q <= 1'b0;
        end else if (req_valid) begin
            oc_q      <= oc_d;
            tgt_q     <= tgt_d;
            syn_q     <= syn_d;
            rdata_q   <= rdata_d;
            nomatch_q <= nomatch_d;
        end
    end

    always_comb begin
        rsp_valid    = (state_q == ST_RESP);
        rsp_outcome  = oc_q;
        rsp_target   = tgt_q;
        rsp_syndrome = syn_q;
        rsp_rdata    = rdata_q;
        rsp_nomatch  = nomatch_q;
        ctl_bits     = ctl_q;
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R10
    trap_syndrome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_outcome == OC_TRAP) |->
            (rsp_syndrome == SYN_CODE[SYN_W-1:0] && rsp_target >= 2'd2));
    // R9
    el0_write_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && cur_el == 2'd0 && req_write) |=>
            (rsp_outcome == OC_UNDEF && $stable(ctl_bits)));
    // R8
    el3_never_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && cur_el == 2'd3) |=> (rsp_outcome != OC_TRAP));
    // R1
    nomatch_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit) |=> (rsp_nomatch && $stable(ctl_bits)));
    // R11
    store_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctl_bits) |-> (rsp_valid && rsp_outcome == OC_WRITE));
endmodule

// File: tb/ugate_router_tb.sv
module ugate_router_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_valid = 0, req_write = 0;
    logic [1:0]  req_op0 = 0;
    logic [2:0]  req_op1 = 0;
    logic [3:0]  req_crn = 0, req_crm = 0;
    logic [2:0]  req_op2 = 0;
    logic [63:0] req_wdata = 0;
    logic [1:0]  cur_el = 0;
    logic [11:0] flags = 0;
    logic        rsp_valid, rsp_nomatch;
    logic [2:0]  rsp_outcome;
    logic [1:0]  rsp_target;
    logic [5:0]  rsp_syndrome;
    logic [63:0] rsp_rdata;
    logic [3:0]  ctl_bits;

    int checks = 0, errors = 0;
    logic [3:0] exp_ctl = 4'h0;
    logic done = 1'b0;

    ugate_router u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .req_wdata(req_wdata), .cur_el(cur_el),
        .l2_enabled(flags[11]), .l3_present(flags[10]), .l1_is64(flags[9]),
        .l2_is64(flags[8]), .l3_is64(flags[7]), .fg_rd_trap(flags[6]),
        .fg_wr_trap(flags[5]), .l2_mon_trap(flags[4]), .l3_mon_trap(flags[3]),
        .l3_fg_enable(flags[2]), .host_mode(flags[1]), .route_to_hyp(flags[0]),
        .rsp_valid(rsp_valid), .rsp_outcome(rsp_outcome), .rsp_target(rsp_target),
        .rsp_syndrome(rsp_syndrome), .rsp_rdata(rsp_rdata), .rsp_nomatch(rsp_nomatch),
        .ctl_bits(ctl_bits)
    );

    // {el[1:0], write, flags[11:0], outcome[2:0], target[1:0]}
    // flags: l2_en l3_pres l1_64 l2_64 l3_64 fg_rd fg_wr l2_mon l3_mon l3_fge host route
    localparam int NV = 23;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 1'b0, 12'b0000_0000_0000, 3'd1, 2'd0}, // R3 nothing set
        {2'd0, 1'b0, 12'b1010_0100_0000, 3'd3, 2'd2}, // R3 fine-grained read
        {2'd0, 1'b0, 12'b1010_0100_0011, 3'd1, 2'd0}, // R4 exempt
        {2'd0, 1'b0, 12'b1010_0100_0010, 3'd3, 2'd2}, // R4 host only
        {2'd0, 1'b0, 12'b1110_0100_0000, 3'd1, 2'd0}, // R4/R3 fge off
        {2'd0, 1'b0, 12'b1110_0100_0100, 3'd3, 2'd2}, // R3 fge on
        {2'd0, 1'b0, 12'b1001_0001_0000, 3'd3, 2'd2}, // R3 l2 monitor
        {2'd0, 1'b0, 12'b1101_1001_1000, 3'd3, 2'd2}, // R3 l2 before l3
        {2'd0, 1'b0, 12'b0100_1000_1000, 3'd3, 2'd3}, // R3 l3 monitor
        {2'd0, 1'b0, 12'b0100_0000_1000, 3'd1, 2'd0}, // R3 l3 not 64-bit
        {2'd0, 1'b0, 12'b0001_0001_0000, 3'd1, 2'd0}, // R3 l2 disabled
        {2'd1, 1'b0, 12'b1001_0100_0011, 3'd3, 2'd2}, // R5 no exemption
        {2'd1, 1'b0, 12'b1010_0100_0000, 3'd1, 2'd0}, // R5 l2 not 64-bit
        {2'd1, 1'b0, 12'b1001_0010_0000, 3'd1, 2'd0}, // R5 write bit ignored
        {2'd1, 1'b1, 12'b1001_0010_0000, 3'd3, 2'd2}, // R6 write trap
        {2'd1, 1'b1, 12'b1001_0100_0000, 3'd2, 2'd0}, // R6 read bit ignored
        {2'd1, 1'b1, 12'b0100_1000_1000, 3'd3, 2'd3}, // R6 l3 monitor
        {2'd2, 1'b0, 12'b1011_0111_0000, 3'd1, 2'd0}, // R7 lower traps ignored
        {2'd2, 1'b1, 12'b0100_1000_1000, 3'd3, 2'd3}, // R7 l3 monitor
        {2'd3, 1'b0, 12'b1111_1111_1111, 3'd1, 2'd0}, // R8 read
        {2'd3, 1'b1, 12'b1111_1111_1111, 3'd2, 2'd0}, // R8 write
        {2'd0, 1'b1, 12'b0000_0000_0000, 3'd4, 2'd0}, // R9
        {2'd0, 1'b1, 12'b1111_1111_1111, 3'd4, 2'd0}  // R9
    };

    function automatic string tag_of(int i);
        if (i <= 1 || (i >= 5 && i <= 10)) return "R3";
        if (i <= 4)  return "R4";
        if (i <= 13) return "R5";
        if (i <= 16) return "R6";
        if (i <= 18) return "R7";
        if (i <= 20) return "R8";
        return "R9";
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic set_enc(input logic match);
        req_op0 = 2'b11; req_op1 = 3'b011; req_crn = 4'b1001; req_crm = 4'b1110;
        req_op2 = match ? 3'b000 : 3'b001;
    endtask

    // Drive one request and return at the negedge where its response is visible
    task automatic access(input logic [1:0] el, input logic wr, input logic [11:0] f,
                          input logic [63:0] wd, input logic match);
        @(negedge clk);
        set_enc(match);
        cur_el = el; req_write = wr; flags = f; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state, R2 no response
        chk("R11", "ctl after reset", {60'd0, ctl_bits}, 64'd0);
        chk("R2", "valid in reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "valid idle", {63'd0, rsp_valid}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            logic [2:0] eo;
            logic [1:0] et;
            eo = VEC[i][4:2];
            et = VEC[i][1:0];
            access(VEC[i][19:18], VEC[i][17], VEC[i][16:5], {60'hA5A5A5A5A5A5A5A, i[3:0]}, 1'b1);
            chk(tag_of(i), "outcome", {61'd0, rsp_outcome}, {61'd0, eo});
            chk(tag_of(i), "target", {62'd0, rsp_target}, {62'd0, et});
            // R10 syndrome tied to outcome
            chk("R10", "syndrome", {58'd0, rsp_syndrome}, (eo == 3'd3) ? 64'h18 : 64'h0);
            chk("R2", "valid", {63'd0, rsp_valid}, 64'd1);
            chk("R1", "nomatch low", {63'd0, rsp_nomatch}, 64'd0);
            // R11 read data reflects stored bits
            chk("R11", "rdata", rsp_rdata, (eo == 3'd1) ? {60'd0, exp_ctl} : 64'd0);
            if (eo == 3'd2) exp_ctl = i[3:0];
            chk("R11", "ctl", {60'd0, ctl_bits}, {60'd0, exp_ctl});
        end

        // R2 valid drops with no request
        @(negedge clk);
        chk("R2", "valid drop", {63'd0, rsp_valid}, 64'd0);

        // R11 write then immediately read
        @(negedge clk);
        set_enc(1'b1);
        cur_el = 2'd3; req_write = 1'b1; flags = 12'h0; req_wdata = 64'hFFFF_FFFF_FFFF_FFF5; req_valid = 1'b1;
        @(negedge clk);
        req_write = 1'b0;
        chk("R11", "write outcome", {61'd0, rsp_outcome}, 64'd2);
        chk("R11", "write rdata zero", rsp_rdata, 64'd0);
        chk("R11", "ctl low bits", {60'd0, ctl_bits}, 64'h5);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11", "b2b read outcome", {61'd0, rsp_outcome}, 64'd1);
        chk("R11", "b2b read data", rsp_rdata, 64'h5);
        chk("R2", "b2b valid", {63'd0, rsp_valid}, 64'd1);

        // R1 mismatched encoding: write at level 3 has no effect
        access(2'd3, 1'b1, 12'h0, 64'hA, 1'b0);
        chk("R1", "nomatch flag", {63'd0, rsp_nomatch}, 64'd1);
        chk("R1", "nomatch outcome", {61'd0, rsp_outcome}, 64'd0);
        chk("R1", "nomatch syndrome", {58'd0, rsp_syndrome}, 64'd0);
        chk("R1", "nomatch ctl", {60'd0, ctl_bits}, 64'h5);
        // R1 mismatch with all traps at level 0
        access(2'd0, 1'b0, 12'hFFF, 64'h0, 1'b0);
        chk("R1", "nomatch no trap", {61'd0, rsp_outcome}, 64'd0);

        // R9 level-0 write leaves register
        access(2'd0, 1'b1, 12'h0, 64'h3, 1'b1);
        chk("R9", "undef ctl", {60'd0, ctl_bits}, 64'h5);
        // R6 trapped level-1 write leaves register
        access(2'd1, 1'b1, 12'b1001_0010_0000, 64'hC, 1'b1);
        chk("R6", "trapped write ctl", {60'd0, ctl_bits}, 64'h5);
        // R6 untrapped level-1 write commits
        access(2'd1, 1'b1, 12'h0, 64'h1234_5678_9ABC_DEF9, 1'b1);
        chk("R6", "level-1 write ctl", {60'd0, ctl_bits}, 64'h9);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule